// File: doc/BRIEF.md
# Single-Precision Float to Integer Converter

This unit takes a 32-bit IEEE-754 binary floating-point operand and turns it into a signed or unsigned integer of 32 or 64 bits. The answer always leaves on a 64-bit bus. Narrow results are widened on that bus by sign extension or by zero extension.

The caller chooses two things at run time. The first is the rounding rule. The second is the policy used when the rounded value does not fit the target type. That policy can be architected saturation, plain saturation, or modular wrap-around. Every conversion also reports four conditions: overflow, invalid conversion, signalling-NaN input, and inexact or fraction-rounded status. When the invalid trap is armed and an invalid condition occurs, the write-enable output is dropped.

The unit has one register stage. Inputs presented before a rising clock edge produce their outputs right after that edge.

Top module: `f2i_conv`

## Requirements
- R1: The integer type is selected by `int_type`:
  - 0 is signed 32-bit, 1 is unsigned 32-bit, 2 is signed 64-bit and 3 is unsigned 64-bit.
  - A 32-bit result fills `res_out[31:0]`.
  - For the signed 32-bit type, bits 63:32 copy bit 31. For the unsigned 32-bit type, bits 63:32 are zero.
- R2: The rounding rule is chosen as follows:
  - When bit 2 of `cvt_mode` is 1, the value is truncated toward zero.
  - Otherwise `rnd_mode` decides: 0 rounds to nearest with ties to even, 1 truncates, 2 rounds toward +infinity and 3 rounds toward -infinity.
- R3: With `cvt_mode` 0 or 1:
  - A NaN yields the type's minimum, which is 0 for the unsigned types.
  - A rounded value above the range yields the maximum.
  - A rounded value below the range yields the minimum. Infinities count as beyond the range.
- R4: With `cvt_mode` 2 or 3, out-of-range values and infinities saturate as in R3, but a NaN yields 0.
- R5: With `cvt_mode` 4 or 5:
  - Infinity and NaN yield 0.
  - Any finite value is truncated and taken as an exact two's-complement integer. Its low 64 bits are kept, and for 32-bit types its low 32 bits are kept before the widening of R1.
- R6: `cvt_mode` 6 and 7 are illegal. They yield a result of 0 with `ovf` and `inv_cvt` set and `inexact` and `frac_up` clear.
- R7: `ovf` and `inv_cvt` are both 1 exactly when any of the following holds; when they are set, `inexact` and `frac_up` are 0:
  - the source is NaN;
  - the source is infinite;
  - the mode is illegal;
  - the rounded value lies outside the target range.
- R8: When `ovf` is 0:
  - `inexact` is 1 exactly when the result differs from the source value.
  - `frac_up` is 1 exactly when the result's magnitude exceeds the source's magnitude.
- R9: When `inv_trap_en` is 1 and either `inv_cvt` or `inv_snan` would be set:
  - `wr_en` is 0 and `inexact` and `frac_up` are forced to 0.
  - The flags and `res_out` still show the computed values.
  - In every other case `wr_en` is 1.
- R10: `inv_snan` is 1 when the operand has an all-ones exponent, a nonzero fraction and fraction bit 22 equal to 0.
- R11: Denormal operands behave as tiny nonzero values:
  - They round to 0, to +1 or to -1 according to the rounding rule.
  - They always set `inexact` unless the range check overflows.
- R12: During reset all outputs are 0. Otherwise every output reflects the inputs sampled at the most recent rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_in | input | 32 | Single-precision operand |
| int_type | input | 2 | Target integer type code |
| cvt_mode | input | 3 | Out-of-range policy and forced-truncation select |
| rnd_mode | input | 2 | Rounding rule code |
| inv_trap_en | input | 1 | Arms suppression of the write on invalid conditions |
| res_out | output | 64 | Converted integer, widened to 64 bits |
| wr_en | output | 1 | Destination write enable |
| ovf | output | 1 | Result does not equal the rounded value |
| inv_cvt | output | 1 | Invalid-conversion flag |
| inv_snan | output | 1 | Signalling-NaN flag |
| inexact | output | 1 | Result differs from the source |
| frac_up | output | 1 | Rounding increased the magnitude |

## Verification
Rounding and range checking can act in the same cycle. A value inside the range can be rounded across its edge. For example, -0.5 converted to an unsigned type toward -infinity becomes -1, so the same conversion must clear `inexact` and saturate to 0.

A saturation and an armed trap can also land together. The bench provokes this with out-of-range and signalling-NaN operands while `inv_trap_en` is high. It then judges that `wr_en` falls while the saturated value and the flags stay visible, and that the rounding status bits read 0.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  localparam int FP_W    = 32;
  localparam int EXP_W   = 8;
  localparam int MAN_W   = 23;
  localparam int BIAS    = 127;
  localparam int INT_W   = 64;
  localparam int MAG_W   = 128;
  localparam int N_TYPES = 4;

  typedef enum logic [1:0] {
    IT_S32 = 2'd0,
    IT_U32 = 2'd1,
    IT_S64 = 2'd2,
    IT_U64 = 2'd3
  } ityp_e;

  typedef enum logic [1:0] {
    RM_NEAR  = 2'd0,
    RM_TRUNC = 2'd1,
    RM_UP    = 2'd2,
    RM_DOWN  = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    POL_ARCH = 2'd0,
    POL_SAT  = 2'd1,
    POL_WRAP = 2'd2,
    POL_BAD  = 2'd3
  } policy_e;

  typedef struct packed {
    logic             sign;
    logic             is_nan;
    logic             is_snan;
    logic             is_inf;
    logic [MAN_W:0]   mant;
    logic [EXP_W-1:0] exp_eff;
  } fp_fields_t;

  typedef struct packed {
    logic             sign;
    logic [MAG_W-1:0] mag;
    logic             inexact;
    logic             incr;
  } rnd_t;

  // Out-of-range policy from the full mode code.
  function automatic policy_e decode_policy(input logic [2:0] mode);
    case (mode)
      3'd0, 3'd1: decode_policy = POL_ARCH;
      3'd2, 3'd3: decode_policy = POL_SAT;
      3'd4, 3'd5: decode_policy = POL_WRAP;
      default:    decode_policy = POL_BAD;
    endcase
  endfunction

  // Whether to bump the truncated magnitude by one.
  function automatic logic round_up(input logic [1:0] rm, input logic sign,
                                    input logic lsb, input logic g, input logic st);
    case (rmode_e'(rm))
      RM_NEAR:  round_up = g & (st | lsb);
      RM_TRUNC: round_up = 1'b0;
      RM_UP:    round_up = ~sign & (g | st);
      default:  round_up = sign & (g | st);
    endcase
  endfunction

  // Low word of the two's-complement value of a sign/magnitude pair.
  function automatic logic [INT_W-1:0] wrap_low(input logic sign, input logic [MAG_W-1:0] mag);
    wrap_low = sign ? (~mag[INT_W-1:0] + INT_W'(1)) : mag[INT_W-1:0];
  endfunction

  // Widen a selected value according to the target type.
  function automatic logic [INT_W-1:0] widen(input logic [1:0] it, input logic [INT_W-1:0] raw);
    case (ityp_e'(it))
      IT_S32:  widen = {{(INT_W/2){raw[INT_W/2-1]}}, raw[INT_W/2-1:0]};
      IT_U32:  widen = {{(INT_W/2){1'b0}}, raw[INT_W/2-1:0]};
      default: widen = raw;
    endcase
  endfunction
endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [FP_W-1:0] fp,
  output fp_fields_t      fld
);
  logic [EXP_W-1:0] exp_raw;
  logic [MAN_W-1:0] frac;
  logic             exp_max;
  logic             exp_min;
  logic             frac_nz;

  assign exp_raw = fp[FP_W-2 -: EXP_W];
  assign frac    = fp[MAN_W-1:0];
  assign exp_max = &exp_raw;
  assign exp_min = ~|exp_raw;
  assign frac_nz = |frac;

  always_comb begin
    fld.sign    = fp[FP_W-1];
    fld.is_nan  = exp_max & frac_nz;
    fld.is_snan = exp_max & frac_nz & ~frac[MAN_W-1];
    fld.is_inf  = exp_max & ~frac_nz;
    fld.mant    = {~exp_min, frac};
    fld.exp_eff = exp_min ? EXP_W'(1) : exp_raw;
  end
endmodule

// File: rtl/f2i_round.sv
module f2i_round
  import f2i_pkg::*;
(
  input  logic             sign,
  input  logic [MAN_W:0]   mant,
  input  logic [EXP_W-1:0] exp_eff,
  input  logic [1:0]       rm,
  output rnd_t             rnd
);
  localparam int SIG_W      = MAN_W + 1;
  localparam int SHIFT_ZERO = BIAS + MAN_W;
  localparam int FRAC_W     = SIG_W + 2;
  localparam int WIN_W      = SIG_W + FRAC_W;
  localparam int E_W        = EXP_W + 1;

  logic [E_W-1:0]   e_ext;
  logic             whole;
  logic [E_W-1:0]   lsh;
  logic [E_W-1:0]   rsh;
  logic [WIN_W-1:0] win;
  logic [SIG_W-1:0] int_part;
  logic             g_bit;
  logic             st_bit;
  logic             bump;

  assign e_ext = {1'b0, exp_eff};
  assign whole = e_ext >= E_W'(SHIFT_ZERO);
  assign lsh   = e_ext - E_W'(SHIFT_ZERO);
  assign rsh   = E_W'(SHIFT_ZERO) - e_ext;
  assign win   = {mant, {FRAC_W{1'b0}}} >> rsh;

  always_comb begin
    if (rsh > E_W'(FRAC_W)) begin
      int_part = '0;
      g_bit    = 1'b0;
      st_bit   = |mant;
    end else begin
      int_part = win[WIN_W-1:FRAC_W];
      g_bit    = win[FRAC_W-1];
      st_bit   = |win[FRAC_W-2:0];
    end
  end

  assign bump = round_up(rm, sign, int_part[0], g_bit, st_bit);

  always_comb begin
    rnd.sign    = sign;
    rnd.mag     = whole ? (MAG_W'(mant) << lsh) : (MAG_W'(int_part) + MAG_W'(bump));
    rnd.inexact = ~whole & (g_bit | st_bit);
    rnd.incr    = ~whole & bump;
  end
endmodule

// File: rtl/f2i_select.sv
module f2i_select
  import f2i_pkg::*;
(
  input  logic             sign,
  input  logic [MAG_W-1:0] mag,
  input  logic             is_nan,
  input  logic             is_inf,
  input  logic [1:0]       int_type,
  input  logic [2:0]       cvt_mode,
  output logic [INT_W-1:0] res,
  output logic             ovf,
  output logic             illegal
);
  logic [N_TYPES-1:0] over_v;
  logic [N_TYPES-1:0] under_v;
  logic [INT_W-1:0]   max_v [N_TYPES];
  logic [INT_W-1:0]   min_v [N_TYPES];

  for (genvar t = 0; t < N_TYPES; t++) begin : g_lim
    localparam int BITS = (t >= 2) ? INT_W : INT_W / 2;
    localparam int SGN  = (t % 2 == 0) ? 1 : 0;
    localparam logic [MAG_W-1:0] HI = (MAG_W'(1) << (BITS - SGN)) - MAG_W'(1);
    localparam logic [MAG_W-1:0] LO = (SGN == 1) ? (MAG_W'(1) << (BITS - 1)) : '0;
    assign over_v[t]  = ~sign & (mag > HI);
    assign under_v[t] = sign & (mag > LO);
    assign max_v[t]   = HI[INT_W-1:0];
    assign min_v[t]   = LO[INT_W-1:0];
  end

  policy_e          pol;
  logic             sat_hi;
  logic             sat_lo;
  logic [INT_W-1:0] raw;

  assign pol     = decode_policy(cvt_mode);
  assign illegal = (pol == POL_BAD);
  assign sat_hi  = is_inf ? ~sign : over_v[int_type];
  assign sat_lo  = is_inf ? sign : under_v[int_type];

  always_comb begin
    raw = '0;
    if (illegal) begin
      raw = '0;
    end else if (is_nan) begin
      raw = (pol == POL_ARCH) ? min_v[int_type] : '0;
    end else if (pol == POL_WRAP) begin
      raw = is_inf ? '0 : wrap_low(sign, mag);
    end else if (sat_hi) begin
      raw = max_v[int_type];
    end else if (sat_lo) begin
      raw = min_v[int_type];
    end else begin
      raw = wrap_low(sign, mag);
    end
  end

  assign res = widen(int_type, raw);
  assign ovf = illegal | is_nan | sat_hi | sat_lo;
endmodule

// File: rtl/f2i_conv.sv
module f2i_conv
  import f2i_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] fp_in,
  input  logic [1:0]  int_type,
  input  logic [2:0]  cvt_mode,
  input  logic [1:0]  rnd_mode,
  input  logic        inv_trap_en,
  output logic [63:0] res_out,
  output logic        wr_en,
  output logic        ovf,
  output logic        inv_cvt,
  output logic        inv_snan,
  output logic        inexact,
  output logic        frac_up
);
  fp_fields_t       fld;
  rnd_t             rnd;
  logic [1:0]       rm_eff;
  logic [INT_W-1:0] res_c;
  logic             ev_ovf;
  logic             ev_illegal;
  logic             ev_trap;
  logic             ev_inx;
  logic             ev_fup;

  f2i_unpack u_unpack (
    .fp  (fp_in),
    .fld (fld)
  );

  assign rm_eff = cvt_mode[2] ? 2'(RM_TRUNC) : rnd_mode;

  f2i_round u_round (
    .sign    (fld.sign),
    .mant    (fld.mant),
    .exp_eff (fld.exp_eff),
    .rm      (rm_eff),
    .rnd     (rnd)
  );

  f2i_select u_select (
    .sign     (rnd.sign),
    .mag      (rnd.mag),
    .is_nan   (fld.is_nan),
    .is_inf   (fld.is_inf),
    .int_type (int_type),
    .cvt_mode (cvt_mode),
    .res      (res_c),
    .ovf      (ev_ovf),
    .illegal  (ev_illegal)
  );

  assign ev_trap = inv_trap_en & (ev_ovf | fld.is_snan);
  assign ev_inx  = ~ev_ovf & ~ev_trap & rnd.inexact;
  assign ev_fup  = ~ev_ovf & ~ev_trap & rnd.incr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_out  <= '0;
      wr_en    <= 1'b0;
      ovf      <= 1'b0;
      inv_cvt  <= 1'b0;
      inv_snan <= 1'b0;
      inexact  <= 1'b0;
      frac_up  <= 1'b0;
    end else begin
      res_out  <= res_c;
      wr_en    <= ~ev_trap;
      ovf      <= ev_ovf;
      inv_cvt  <= ev_ovf;
      inv_snan <= fld.is_snan;
      inexact  <= ev_inx;
      frac_up  <= ev_fup;
    end
  end
endmodule

// File: rtl/f2i_conv_chk.sv
module f2i_conv_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  int_type,
  input logic [2:0]  cvt_mode,
  input logic [63:0] res_out,
  input logic        wr_en,
  input logic        ovf,
  input logic        inv_cvt,
  input logic        inv_snan,
  input logic        inexact,
  input logic        frac_up,
  input logic        ev_illegal
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ovf) |-> (!inexact && !frac_up));

  assert_frac_inexact_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && frac_up) |-> inexact);

  assert_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !wr_en) |-> ((inv_cvt || inv_snan) && !inexact && !frac_up));

  assert_snan_invalid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && inv_snan) |-> (ovf && inv_cvt));

  assert_zero_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(int_type) == 2'd1) |-> (res_out[63:32] == 32'd0));

  assert_sign_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(int_type) == 2'd0) |-> (res_out[63:32] == {32{res_out[31]}}));

  assert_illegal_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cvt_mode[2:1]) == 2'b11) |-> (inv_cvt && res_out == 64'd0 && !inexact));

  assert_illegal_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(ev_illegal)) |-> (ovf && !frac_up));
endmodule

bind f2i_conv f2i_conv_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .int_type   (int_type),
  .cvt_mode   (cvt_mode),
  .res_out    (res_out),
  .wr_en      (wr_en),
  .ovf        (ovf),
  .inv_cvt    (inv_cvt),
  .inv_snan   (inv_snan),
  .inexact    (inexact),
  .frac_up    (frac_up),
  .ev_illegal (ev_illegal)
);

// File: tb/f2i_conv_tb_top.sv
module f2i_conv_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fp_in = '0;
  logic [1:0]  int_type = '0;
  logic [2:0]  cvt_mode = '0;
  logic [1:0]  rnd_mode = '0;
  logic        inv_trap_en = 1'b0;
  logic [63:0] res_out;
  logic        wr_en, ovf, inv_cvt, inv_snan, inexact, frac_up;

  int checks = 0;
  int failures = 0;

  localparam logic [63:0] ONES   = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] S32MIN = 64'hFFFF_FFFF_8000_0000;
  localparam logic [63:0] S64MIN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] S64MAX = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [31:0] F_NAN  = 32'h7FC0_0000;

  always #5 clk = ~clk;

  f2i_conv dut_i (
    .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .int_type(int_type),
    .cvt_mode(cvt_mode), .rnd_mode(rnd_mode), .inv_trap_en(inv_trap_en),
    .res_out(res_out), .wr_en(wr_en), .ovf(ovf), .inv_cvt(inv_cvt),
    .inv_snan(inv_snan), .inexact(inexact), .frac_up(frac_up)
  );

  task automatic chk(input logic [31:0] fp, input logic [1:0] it, input logic [2:0] cm,
                     input logic [1:0] rm, input logic ie, input logic [63:0] e_res,
                     input logic e_wen, input logic e_ovf, input logic e_snan,
                     input logic e_inx, input logic e_fup, input string req);
    fp_in = fp; int_type = it; cvt_mode = cm; rnd_mode = rm; inv_trap_en = ie;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if ({res_out, wr_en, ovf, inv_cvt, inv_snan, inexact, frac_up} !==
        {e_res, e_wen, e_ovf, e_ovf, e_snan, e_inx, e_fup}) begin
      failures++;
      $display("FAIL %s fp=%h: got res=%h wen=%b ovf=%b icv=%b snan=%b inx=%b fr=%b expected res=%h wen=%b ovf=%b icv=%b snan=%b inx=%b fr=%b",
               req, fp, res_out, wr_en, ovf, inv_cvt, inv_snan, inexact, frac_up,
               e_res, e_wen, e_ovf, e_ovf, e_snan, e_inx, e_fup);
    end
  endtask

  task automatic t_reset;
    checks++;
    if ({res_out, wr_en, ovf, inv_cvt, inv_snan, inexact, frac_up} !== 70'd0) begin
      failures++;
      $display("FAIL R12 reset: got res=%h wen=%b flags=%b%b%b%b%b expected all 0",
               res_out, wr_en, ovf, inv_cvt, inv_snan, inexact, frac_up);
    end
  endtask

  task automatic t_types;
    chk(32'h3F80_0000, 2'd0, 3'd0, 2'd0, 0, 64'd1, 1, 0, 0, 0, 0, "R1 s32 one");
    chk(32'hBF80_0000, 2'd0, 3'd0, 2'd0, 0, ONES, 1, 0, 0, 0, 0, "R1 s32 minus one");
    chk(32'hBF80_0000, 2'd2, 3'd0, 2'd0, 0, ONES, 1, 0, 0, 0, 0, "R1 s64 minus one");
    chk(32'h4F7F_FFFF, 2'd1, 3'd0, 2'd0, 0, 64'h0000_0000_FFFF_FF00, 1, 0, 0, 0, 0, "R1 u32 near max");
    chk(32'hCF00_0000, 2'd0, 3'd0, 2'd0, 0, S32MIN, 1, 0, 0, 0, 0, "R1 s32 min exact");
    chk(32'h5380_0000, 2'd2, 3'd0, 2'd0, 0, 64'h0000_0100_0000_0000, 1, 0, 0, 0, 0, "R1 s64 2^40");
    chk(32'h5F00_0000, 2'd3, 3'd0, 2'd0, 0, S64MIN, 1, 0, 0, 0, 0, "R1 u64 2^63");
    chk(32'h0000_0000, 2'd1, 3'd0, 2'd0, 0, 64'd0, 1, 0, 0, 0, 0, "R1 zero");
    chk(32'h8000_0000, 2'd1, 3'd0, 2'd0, 0, 64'd0, 1, 0, 0, 0, 0, "R1 negative zero u32");
  endtask

  task automatic t_round;
    chk(32'h3FC0_0000, 2'd2, 3'd0, 2'd0, 0, 64'd2, 1, 0, 0, 1, 1, "R2 1.5 nearest");
    chk(32'h4020_0000, 2'd2, 3'd0, 2'd0, 0, 64'd2, 1, 0, 0, 1, 0, "R2 2.5 nearest even");
    chk(32'h3F00_0000, 2'd2, 3'd0, 2'd0, 0, 64'd0, 1, 0, 0, 1, 0, "R2 0.5 nearest even");
    chk(32'h3FC0_0000, 2'd2, 3'd0, 2'd1, 0, 64'd1, 1, 0, 0, 1, 0, "R2 1.5 truncate");
    chk(32'hBFC0_0000, 2'd2, 3'd0, 2'd2, 0, ONES, 1, 0, 0, 1, 0, "R2 -1.5 ceiling");
    chk(32'hBFC0_0000, 2'd2, 3'd0, 2'd3, 0, ONES - 64'd1, 1, 0, 0, 1, 1, "R2 -1.5 floor");
    chk(32'h3FC0_0000, 2'd2, 3'd1, 2'd2, 0, 64'd2, 1, 0, 0, 1, 1, "R2 1.5 ceiling mode1");
    chk(32'h3FC0_0000, 2'd2, 3'd4, 2'd2, 0, 64'd1, 1, 0, 0, 1, 0, "R2 forced truncate");
    chk(32'hC020_0000, 2'd2, 3'd5, 2'd3, 0, ONES - 64'd1, 1, 0, 0, 1, 0, "R2 forced truncate neg");
  endtask

  task automatic t_arch;
    chk(F_NAN,         2'd0, 3'd0, 2'd0, 0, S32MIN, 1, 1, 0, 0, 0, "R3 nan s32");
    chk(F_NAN,         2'd1, 3'd1, 2'd0, 0, 64'd0, 1, 1, 0, 0, 0, "R3 nan u32");
    chk(F_NAN,         2'd2, 3'd1, 2'd0, 0, S64MIN, 1, 1, 0, 0, 0, "R3 nan s64");
    chk(32'h4F00_0000, 2'd0, 3'd0, 2'd0, 0, 64'h7FFF_FFFF, 1, 1, 0, 0, 0, "R3 2^31 s32 high");
    chk(32'h5F00_0000, 2'd2, 3'd0, 2'd0, 0, S64MAX, 1, 1, 0, 0, 0, "R3 2^63 s64 high");
    chk(32'hFF80_0000, 2'd2, 3'd0, 2'd0, 0, S64MIN, 1, 1, 0, 0, 0, "R3 -inf s64");
    chk(32'hBF80_0000, 2'd1, 3'd0, 2'd0, 0, 64'd0, 1, 1, 0, 0, 0, "R3 -1 u32 low");
    chk(32'h4F80_0000, 2'd1, 3'd1, 2'd0, 0, 64'h0000_0000_FFFF_FFFF, 1, 1, 0, 0, 0, "R3 2^32 u32 high");
    chk(32'hBF00_0000, 2'd1, 3'd0, 2'd3, 0, 64'd0, 1, 1, 0, 0, 0, "R3 -0.5 floor u32 low");
    chk(32'hBF00_0000, 2'd1, 3'd0, 2'd0, 0, 64'd0, 1, 0, 0, 1, 0, "R8 -0.5 nearest u32 in range");
  endtask

  task automatic t_sat;
    chk(F_NAN,         2'd2, 3'd2, 2'd0, 0, 64'd0, 1, 1, 0, 0, 0, "R4 nan s64");
    chk(F_NAN,         2'd0, 3'd3, 2'd0, 0, 64'd0, 1, 1, 0, 0, 0, "R4 nan s32");
    chk(32'h7F80_0000, 2'd3, 3'd2, 2'd0, 0, ONES, 1, 1, 0, 0, 0, "R4 +inf u64");
    chk(32'hCF40_0000, 2'd0, 3'd3, 2'd0, 0, S32MIN, 1, 1, 0, 0, 0, "R4 s32 low");
  endtask

  task automatic t_wrap;
    chk(32'h4FC0_0000, 2'd0, 3'd4, 2'd0, 0, S32MIN, 1, 1, 0, 0, 0, "R5 wrap s32");
    chk(32'h4FC0_0000, 2'd1, 3'd4, 2'd0, 0, 64'h8000_0000, 1, 1, 0, 0, 0, "R5 wrap u32");
    chk(32'h5000_0000, 2'd1, 3'd5, 2'd0, 0, 64'd0, 1, 1, 0, 0, 0, "R5 2^33 u32");
    chk(32'hBF80_0000, 2'd3, 3'd4, 2'd0, 0, ONES, 1, 1, 0, 0, 0, "R5 -1 u64");
    chk(32'h7F7F_FFFF, 2'd2, 3'd5, 2'd0, 0, 64'd0, 1, 1, 0, 0, 0, "R5 max float s64");
    chk(32'h5F80_0000, 2'd3, 3'd4, 2'd0, 0, 64'd0, 1, 1, 0, 0, 0, "R5 2^64 u64");
    chk(32'h7F80_0000, 2'd2, 3'd4, 2'd0, 0, 64'd0, 1, 1, 0, 0, 0, "R5 +inf");
    chk(F_NAN,         2'd0, 3'd5, 2'd0, 0, 64'd0, 1, 1, 0, 0, 0, "R5 nan");
    chk(32'h3F80_0000, 2'd1, 3'd4, 2'd0, 0, 64'd1, 1, 0, 0, 0, 0, "R5 in range");
    chk(32'hBFC0_0000, 2'd0, 3'd4, 2'd3, 0, ONES, 1, 0, 0, 1, 0, "R5 neg truncated");
  endtask

  task automatic t_illegal;
    chk(32'h3F80_0000, 2'd2, 3'd6, 2'd0, 0, 64'd0, 1, 1, 0, 0, 0, "R6 mode 6");
    chk(32'h3FC0_0000, 2'd0, 3'd7, 2'd2, 0, 64'd0, 1, 1, 0, 0, 0, "R6 mode 7");
  endtask

  task automatic t_trap;
    chk(F_NAN,         2'd0, 3'd0, 2'd0, 1, S32MIN, 0, 1, 0, 0, 0, "R9 nan trapped");
    chk(32'h3FC0_0000, 2'd2, 3'd0, 2'd0, 1, 64'd2, 1, 0, 0, 1, 1, "R9 valid not trapped");
    chk(32'h4F00_0000, 2'd0, 3'd0, 2'd0, 1, 64'h7FFF_FFFF, 0, 1, 0, 0, 0, "R9 saturation trapped");
    chk(32'h3F80_0000, 2'd2, 3'd6, 2'd0, 1, 64'd0, 0, 1, 0, 0, 0, "R9 illegal trapped");
    chk(32'h7F80_0001, 2'd2, 3'd2, 2'd0, 1, 64'd0, 0, 1, 1, 0, 0, "R9 snan trapped");
  endtask

  task automatic t_snan;
    chk(32'h7F80_0001, 2'd2, 3'd2, 2'd0, 0, 64'd0, 1, 1, 1, 0, 0, "R10 snan low bit");
    chk(32'h7FA0_0000, 2'd0, 3'd0, 2'd0, 0, S32MIN, 1, 1, 1, 0, 0, "R10 snan high bit");
    chk(32'h7FC0_0001, 2'd2, 3'd2, 2'd0, 0, 64'd0, 1, 1, 0, 0, 0, "R10 quiet nan");
  endtask

  task automatic t_denorm;
    chk(32'h0000_0001, 2'd2, 3'd0, 2'd0, 0, 64'd0, 1, 0, 0, 1, 0, "R11 denormal nearest");
    chk(32'h0000_0001, 2'd2, 3'd0, 2'd2, 0, 64'd1, 1, 0, 0, 1, 1, "R11 denormal ceiling");
    chk(32'h8000_0001, 2'd2, 3'd0, 2'd3, 0, ONES, 1, 0, 0, 1, 1, "R11 neg denormal floor");
    chk(32'h8000_0001, 2'd2, 3'd0, 2'd2, 0, 64'd0, 1, 0, 0, 1, 0, "R11 neg denormal ceiling");
    chk(32'h8000_0001, 2'd1, 3'd0, 2'd3, 0, 64'd0, 1, 1, 0, 0, 0, "R11 neg denormal floor u32");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_types();
    t_round();
    t_arch();
    t_sat();
    t_wrap();
    t_illegal();
    t_trap();
    t_snan();
    t_denorm();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule